// File: doc/BRIEF.md
# Multi-Bus Bridge Control Unit

This block sequences one transfer through a bridge that joins several buses. It sits idle, touching no adapter, until the arbiter asserts one of its grant lines. On that edge it decodes the destination address and stores the result. An address inside one of the configured windows selects exactly one adapter module through a chip select. An address outside every window raises an illegal-address flag instead.

For a legal target the unit runs a strict four-phase handshake with the chosen adapter:

1. Raise that adapter's request line.
2. Wait for the acknowledge.
3. Drop the request.
4. Wait for the acknowledge to fall.

It then removes the chip select and waits until every grant line is low before it returns to idle. An illegal address skips the handshake and goes straight to the grant-release wait.

The adapters share one acknowledge path. Each adapter acknowledge is gated by its own chip select before the OR, so an adapter that is not selected cannot affect the sequence.

Top module: `bridge_ctrl`

## Requirements
- R1: After a synchronous reset, `cs_o`, `req_o` and `illegal_o` are all zero. Reset applied in the middle of a transfer abandons it and returns the unit to idle.
- R2: While every grant line is low and the unit is idle, no chip select, request or illegal flag is raised, whatever the address.
- R3: Adapter i (i = 0..N_ADP-1) owns addresses BASE + i*2^SPAN_LG up to BASE + (i+1)*2^SPAN_LG - 1. With the defaults (BASE 0x1000, SPAN_LG 10, three adapters) this gives 0x1000-0x13FF for cs bit 0, 0x1400-0x17FF for bit 1 and 0x1800-0x1BFF for bit 2. The matching `cs_o` bit is 1 from the cycle after the first clock edge that sees a grant high.
- R4: An address outside all windows raises `illegal_o` in place of any chip select or request. The flag stays high until the cycle after all grants are low.
- R5: For a legal target, `req_o` equals `cs_o` and holds until the selected adapter's acknowledge is seen high.
- R6: The clock edge that sees the selected acknowledge high clears `req_o`, and `cs_o` is kept.
- R7: With the request low, the edge that sees the selected acknowledge low clears `cs_o`.
- R8: After the chip select is removed, the unit waits while any grant is high and starts no new transfer. It is idle after the first edge that sees all grants low, and a grant asserted after that starts a fresh transfer.
- R9: An acknowledge from an adapter whose chip select is low has no effect on `req_o` or `cs_o`.
- R10: The address is captured when the transfer starts. Later changes to `addr_i` do not alter `cs_o`.
- R11: At most one `cs_o` bit is high, and a `req_o` bit is never high without its `cs_o` bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| grant_i | input | N_GRANT (4) | Grant lines from the arbiter |
| addr_i | input | ADDR_W (16) | Destination address of the granted master |
| ack_i | input | N_ADP (3) | Per-adapter acknowledge lines |
| req_o | output | N_ADP (3) | Per-adapter request lines |
| cs_o | output | N_ADP (3) | One-hot adapter chip selects |
| illegal_o | output | 1 | Destination address matches no window |

## Verification
Two cases put separate functions into the same clock cycle.

The first is the fall of the selected acknowledge landing in the same cycle as the release of the grants. The bench drops both together and expects one cycle with the chip select cleared before the unit is idle. It then checks that a grant raised right after that starts a clean new transfer.

The second is an acknowledge from an unselected adapter arriving while the handshake waits. The bench raises the other adapters' acknowledges during the request phase and judges that the request and chip select hold. It then raises the selected one alongside them and expects the request to drop on that edge.

// File: rtl/bridge_ctrl_pkg.sv
package bridge_ctrl_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_DROP = 2'd2,
        ST_REL  = 2'd3
    } hs_state_e;

    // Low edge of the window owned by adapter idx.
    function automatic longint win_lo(input longint base, input int span_lg, input int idx);
        return base + (longint'(idx) << span_lg);
    endfunction

endpackage

// File: rtl/bc_addr_decode.sv
module bc_addr_decode #(
    parameter int     ADDR_W  = 16,
    parameter int     N_ADP   = 3,
    parameter longint BASE    = 64'h1000,
    parameter int     SPAN_LG = 10
) (
    input  logic [ADDR_W-1:0] addr_i,
    output logic [N_ADP-1:0]  sel_o,
    output logic              illegal_o
);
    import bridge_ctrl_pkg::*;

    localparam int CW = ADDR_W + 2;

    logic [CW-1:0] addr_ext;
    assign addr_ext = CW'(addr_i);

    for (genvar i = 0; i < N_ADP; i++) begin : g_win
        localparam logic [CW-1:0] LO = CW'(win_lo(BASE, SPAN_LG, i));
        localparam logic [CW-1:0] HI = CW'(win_lo(BASE, SPAN_LG, i + 1));
        assign sel_o[i] = (addr_ext >= LO) && (addr_ext < HI);
    end

    assign illegal_o = ~|sel_o;

    // R3
    always_comb begin
        dec_onehot_chk: assert ($onehot0(sel_o) && (illegal_o != (|sel_o)));
    end

endmodule

// File: rtl/bc_ack_merge.sv
module bc_ack_merge #(
    parameter int N_ADP = 3
) (
    input  logic [N_ADP-1:0] ack_i,
    input  logic [N_ADP-1:0] cs_i,
    output logic             ack_o
);
    logic [N_ADP-1:0] gated;

    for (genvar i = 0; i < N_ADP; i++) begin : g_gate
        assign gated[i] = ack_i[i] & cs_i[i];
    end

    assign ack_o = |gated;

endmodule

// File: rtl/bc_hs_fsm.sv
module bc_hs_fsm #(
    parameter int N_ADP = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             grant_any_i,
    input  logic [N_ADP-1:0] dec_sel_i,
    input  logic             dec_illegal_i,
    input  logic             ack_i,
    output logic [N_ADP-1:0] cs_o,
    output logic [N_ADP-1:0] req_o,
    output logic             illegal_o
);
    import bridge_ctrl_pkg::*;

    hs_state_e        state;
    logic [N_ADP-1:0] sel_q;
    logic             ill_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            sel_q <= '0;
            ill_q <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: if (grant_any_i) begin
                    sel_q <= dec_sel_i;
                    ill_q <= dec_illegal_i;
                    state <= dec_illegal_i ? ST_REL : ST_REQ;
                end
                ST_REQ:  if (ack_i)        state <= ST_DROP;
                ST_DROP: if (!ack_i)       state <= ST_REL;
                ST_REL:  if (!grant_any_i) state <= ST_IDLE;
                default:                   state <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        cs_o      = '0;
        req_o     = '0;
        illegal_o = 1'b0;
        if (state == ST_REQ || state == ST_DROP) cs_o = sel_q;
        if (state == ST_REQ) req_o = sel_q;
        if (state == ST_REL) illegal_o = ill_q;
    end

    // R11
    cs_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(cs_o) && ((req_o & ~cs_o) == '0));
    // R5
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (|req_o && !ack_i) |=> $stable(req_o) && $stable(cs_o));
    // R6
    req_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (|req_o && ack_i) |=> (req_o == '0) && $stable(cs_o));
    // R7
    cs_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (|cs_o && !(|req_o) && !ack_i) |=> (cs_o == '0));
    // R4
    illegal_excl_chk: assert property (@(posedge clk) disable iff (rst)
        illegal_o |-> (cs_o == '0) && (req_o == '0));
    // R8
    release_wait_chk: assert property (@(posedge clk) disable iff (rst)
        (illegal_o && grant_any_i) |=> illegal_o);
    // R2
    start_grant_chk: assert property (@(posedge clk) disable iff (rst)
        ((cs_o == '0) && !illegal_o && !grant_any_i) |=> (cs_o == '0) && !illegal_o);

endmodule

// File: rtl/bridge_ctrl.sv
module bridge_ctrl #(
    parameter int     N_GRANT = 4,
    parameter int     ADDR_W  = 16,
    parameter int     N_ADP   = 3,
    parameter longint BASE    = 64'h1000,
    parameter int     SPAN_LG = 10
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [N_GRANT-1:0] grant_i,
    input  logic [ADDR_W-1:0]  addr_i,
    input  logic [N_ADP-1:0]   ack_i,
    output logic [N_ADP-1:0]   req_o,
    output logic [N_ADP-1:0]   cs_o,
    output logic               illegal_o
);
    logic             grant_any;
    logic [N_ADP-1:0] dec_sel;
    logic             dec_ill;
    logic             ack_bus;

    assign grant_any = |grant_i;

    bc_addr_decode #(
        .ADDR_W (ADDR_W),
        .N_ADP  (N_ADP),
        .BASE   (BASE),
        .SPAN_LG(SPAN_LG)
    ) u_dec (
        .addr_i   (addr_i),
        .sel_o    (dec_sel),
        .illegal_o(dec_ill)
    );

    bc_ack_merge #(.N_ADP(N_ADP)) u_ack (
        .ack_i(ack_i),
        .cs_i (cs_o),
        .ack_o(ack_bus)
    );

    bc_hs_fsm #(.N_ADP(N_ADP)) u_fsm (
        .clk          (clk),
        .rst          (rst),
        .grant_any_i  (grant_any),
        .dec_sel_i    (dec_sel),
        .dec_illegal_i(dec_ill),
        .ack_i        (ack_bus),
        .cs_o         (cs_o),
        .req_o        (req_o),
        .illegal_o    (illegal_o)
    );

endmodule

// File: tb/tb_bridge_ctrl.sv
module tb_bridge_ctrl;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  grant_i = '0;
    logic [15:0] addr_i = '0;
    logic [2:0]  ack_i = '0;
    logic [2:0]  req_o, cs_o;
    logic        illegal_o;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    bridge_ctrl dut (
        .clk(clk), .rst(rst), .grant_i(grant_i), .addr_i(addr_i),
        .ack_i(ack_i), .req_o(req_o), .cs_o(cs_o), .illegal_o(illegal_o)
    );

    // {addr, expected cs, expected illegal}
    localparam logic [19:0] VEC [8] = '{
        {16'h1000, 3'b001, 1'b0},
        {16'h13FF, 3'b001, 1'b0},
        {16'h1400, 3'b010, 1'b0},
        {16'h17FF, 3'b010, 1'b0},
        {16'h1800, 3'b100, 1'b0},
        {16'h1BFF, 3'b100, 1'b0},
        {16'h1C00, 3'b000, 1'b1},
        {16'h0FFF, 3'b000, 1'b1}
    };

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic run_txn(input logic [15:0] a, input logic [2:0] ecs, input logic eill);
        @(negedge clk);
        addr_i  = a;
        grant_i = 4'b0010;
        @(negedge clk);
        check("R3 cs", {5'b0, cs_o}, {5'b0, ecs});
        check("R4 illegal", {7'b0, illegal_o}, {7'b0, eill});
        check("R5 req", {5'b0, req_o}, {5'b0, ecs});
        if (!eill) begin
            addr_i = ~a;
            @(negedge clk);
            check("R10 cs after addr change", {5'b0, cs_o}, {5'b0, ecs});
            check("R5 req held", {5'b0, req_o}, {5'b0, ecs});
            ack_i = ecs;
            @(negedge clk);
            check("R6 req dropped", {5'b0, req_o}, 8'h0);
            check("R6 cs kept", {5'b0, cs_o}, {5'b0, ecs});
            ack_i = '0;
            @(negedge clk);
            check("R7 cs removed", {5'b0, cs_o}, 8'h0);
        end
        @(negedge clk);
        check("R8 no restart under grant", {4'b0, cs_o, illegal_o}, {4'b0, 3'b0, eill});
        grant_i = '0;
        @(negedge clk);
        check("R8 idle after release", {4'b0, cs_o, illegal_o}, 8'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset cs/req/illegal", {1'b0, cs_o, req_o, illegal_o}, 8'h0);
        rst = 1'b0;

        // R2: legal address, no grant
        addr_i = 16'h1400;
        repeat (4) @(negedge clk);
        check("R2 no grant", {1'b0, cs_o, req_o, illegal_o}, 8'h0);

        for (int k = 0; k < 8; k++) begin
            run_txn(VEC[k][19:4], VEC[k][3:1], VEC[k][0]);
        end

        // R9: unselected acknowledges ignored
        @(negedge clk);
        addr_i  = 16'h1400;
        grant_i = 4'b1000;
        @(negedge clk);
        ack_i = 3'b101;
        @(negedge clk);
        check("R9 req with foreign ack", {5'b0, req_o}, 8'h02);
        check("R9 cs with foreign ack", {5'b0, cs_o}, 8'h02);
        check("R11 onehot cs", {7'b0, $onehot0(cs_o)}, 8'h1);
        ack_i = 3'b111;
        @(negedge clk);
        check("R6 req drop with all acks", {5'b0, req_o}, 8'h0);
        // ack fall and grant release in the same cycle
        ack_i   = '0;
        grant_i = '0;
        @(negedge clk);
        check("R7 cs cleared with grant release", {5'b0, cs_o}, 8'h0);
        @(negedge clk);
        check("R8 idle", {1'b0, cs_o, req_o, illegal_o}, 8'h0);
        addr_i  = 16'h1800;
        grant_i = 4'b0001;
        @(negedge clk);
        check("R8 fresh transfer", {5'b0, cs_o}, 8'h04);

        // R1: reset mid-transfer
        rst = 1'b1;
        @(negedge clk);
        check("R1 mid-transfer reset", {1'b0, cs_o, req_o, illegal_o}, 8'h0);
        rst     = 1'b0;
        grant_i = '0;
        @(negedge clk);
        check("R1 idle after reset", {1'b0, cs_o, req_o, illegal_o}, 8'h0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule